// File: doc/BRIEF.md
# Double-Buffered Compare PWM Generator

This block drives one pulse-width-modulated output from an up-counting timebase. The counter runs from zero to a programmable period and then wraps to zero. Two compare channels, A and B, are each matched against the counter. Each channel keeps a working value that the comparator uses and a staging value that software writes. In staged mode the staging value moves into the working value only on a chosen counter event. A duty-cycle change made at any moment therefore starts on a period boundary and never cuts a pulse short.

The output level is set by an event action table. Four events are decoded: counter at zero, counter at period, counter at compare A and counter at compare B. Each event carries a 2-bit action code: 0 leaves the output as it is, 1 drives it low, 2 drives it high and 3 inverts it. With action 2 on the period event and action 1 on compare A, compare A alone sets the duty cycle. With action 3 on both compares, the result depends on the level the output already has. Changing one compare in that setup can swap the high and low times, and the block keeps that behaviour.

Configuration arrives as register writes on a valid/ready port. `cfg_ready` is always high, so every cycle with `cfg_valid` high transfers one write and there is no back-pressure. Address map: 0 = period, 1 = compare A, 2 = compare B, 3 = compare mode, 4 = action table.

Top module: `pwm_shadow_gen`

## Requirements
- R1: While `run_en` is high, the counter advances by one each cycle and returns to 0 in the cycle after it equals the period (or exceeds it).
- R2: With staging off for a channel (mode bit 2 for A, bit 5 for B equal to 0), a write to that compare is used by the comparator from the next cycle.
- R3: With staging on and load select 0 (A: mode bits 1:0, B: bits 4:3), the staged value becomes the working value at the end of a cycle in which the counter is 0.
- R4: With staging on and load select 1, the staged value becomes the working value at the end of a cycle in which the counter equals the period.
- R5: With staging on and load select 2 or 3, the working value never changes, whatever is written.
- R6: Action-table bits 1:0 (zero event), 3:2 (period event), 5:4 (compare A event) and 9:8 (compare B event) hold codes 0 none, 1 low, 2 high, 3 invert. The output register applies the chosen code at the end of the event cycle.
- R7: When several events fall in one cycle, the code that is not none and comes first in the order period, compare B, compare A, zero decides the output.
- R8: A working compare value above the period never produces a match, so the output keeps its level.
- R9: When a staging write and a load event fall in the same cycle, the load takes the previous staged value. The new value waits for the next load event.
- R10: Reset forces the output low. While `run_en` is low, the counter is held at 0 and the output holds its level.
- R11: Action-table bits 7:6 and 11:10 (compare events while counting down) have no effect, because the counter only counts up.
- R12: `cfg_ready` is high in every cycle, and each cycle with `cfg_valid` high applies exactly one write.
- R13: With action 3 on both compare events, the output inverts at each match. A compare change therefore shifts the toggle points without restoring any fixed polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter run enable |
| cfg_valid | input | 1 | Register write request |
| cfg_ready | output | 1 | Write accepted (always high) |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | CNT_W | Register write data |
| pwm_out | output | 1 | PWM output |

## Verification
Two collisions matter most. A staging write can land on the same cycle as the load event that would move it. Several match events can also fire on the same counter value. The bench writes compare A on every cycle across a whole period, so one write is sure to meet the load event. It also sets compare A and compare B equal to the period, and compare A equal to zero, so that matches pile onto the same cycle. A behavioural model judges every cycle's output: it loads the staged value before it applies the write, and it resolves colliding actions in the stated priority order.

// File: rtl/pwm_sg_pkg.sv
package pwm_sg_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_INVERT = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LD_AT_ZERO = 2'd0,
    LD_AT_PRD  = 2'd1,
    LD_OFF     = 2'd2,
    LD_OFF_ALT = 2'd3
  } ld_e;

  typedef struct packed {
    logic staged;
    ld_e  sel;
  } cmp_mode_t;

  typedef struct packed {
    act_e on_b;
    act_e on_a;
    act_e on_prd;
    act_e on_zero;
  } act_tbl_t;

  localparam logic [2:0] REG_PERIOD = 3'd0;
  localparam logic [2:0] REG_CMP_A  = 3'd1;
  localparam logic [2:0] REG_CMP_B  = 3'd2;
  localparam logic [2:0] REG_MODE   = 3'd3;
  localparam logic [2:0] REG_ACTION = 3'd4;
  localparam int         NUM_CMP    = 2;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             at_zero,
  output logic             at_prd
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) count <= '0;
    else if (count >= period) count <= '0;
    else count <= count + 1'b1;
  end

  assign at_zero = run_en && (count == '0);
  assign at_prd  = run_en && (count == period);
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_sg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmp_mode_t        mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             at_zero,
  input  logic             at_prd,
  output logic [CNT_W-1:0] work_val
);
  logic [CNT_W-1:0] stage_q;
  logic             load_now;

  always_comb begin
    load_now = 1'b0;
    if (mode.staged) begin
      unique case (mode.sel)
        LD_AT_ZERO: load_now = at_zero;
        LD_AT_PRD:  load_now = at_prd;
        default:    load_now = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      work_val <= '0;
    end else begin
      if (load_now) work_val <= stage_q;
      if (wr_en) begin
        stage_q <= wr_val;
        if (!mode.staged) work_val <= wr_val;
      end
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_sg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  act_tbl_t         tbl,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             at_zero,
  input  logic             at_prd,
  output logic             pwm_out
);
  logic hit_a, hit_b;
  act_e pick;

  assign hit_a = run_en && (count == cmp_a) && (cmp_a <= period);
  assign hit_b = run_en && (count == cmp_b) && (cmp_b <= period);

  always_comb begin
    if (at_prd && tbl.on_prd != ACT_NONE)       pick = tbl.on_prd;
    else if (hit_b && tbl.on_b != ACT_NONE)     pick = tbl.on_b;
    else if (hit_a && tbl.on_a != ACT_NONE)     pick = tbl.on_a;
    else if (at_zero && tbl.on_zero != ACT_NONE) pick = tbl.on_zero;
    else                                        pick = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else begin
      unique case (pick)
        ACT_LOW:    pwm_out <= 1'b0;
        ACT_HIGH:   pwm_out <= 1'b1;
        ACT_INVERT: pwm_out <= ~pwm_out;
        default:    pwm_out <= pwm_out;
      endcase
    end
  end
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_sg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRD_RST = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_data,
  output logic             pwm_out
);
  localparam int MODE_W = $bits(cmp_mode_t);

  logic             accept;
  logic [CNT_W-1:0] prd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero, at_prd;
  cmp_mode_t        mode_q [NUM_CMP];
  logic [CNT_W-1:0] work   [NUM_CMP];
  act_tbl_t         tbl_q;
  logic [CNT_W-1:0] cmp_act_a;
  logic [2:0]       cmp_mode_a;

  assign cfg_ready = 1'b1;
  assign accept    = cfg_valid && cfg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q <= CNT_W'(PRD_RST);
      tbl_q <= '0;
    end else if (accept) begin
      if (cfg_addr == REG_PERIOD) prd_q <= cfg_data;
      if (cfg_addr == REG_ACTION)
        tbl_q <= act_tbl_t'({cfg_data[9:8], cfg_data[5:4], cfg_data[3:2], cfg_data[1:0]});
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(prd_q),
    .count(cnt_q), .at_zero(at_zero), .at_prd(at_prd)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam logic [2:0] MY_ADDR = (g == 0) ? REG_CMP_A : REG_CMP_B;

    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[g] <= '0;
      else if (accept && cfg_addr == REG_MODE)
        mode_q[g] <= cmp_mode_t'(cfg_data[g*MODE_W +: MODE_W]);
    end

    pwm_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .mode(mode_q[g]),
      .wr_en(accept && cfg_addr == MY_ADDR), .wr_val(cfg_data),
      .at_zero(at_zero), .at_prd(at_prd), .work_val(work[g])
    );
  end

  assign cmp_act_a  = work[0];
  assign cmp_mode_a = mode_q[0];

  pwm_action #(.CNT_W(CNT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tbl(tbl_q),
    .count(cnt_q), .period(prd_q), .cmp_a(work[0]), .cmp_b(work[1]),
    .at_zero(at_zero), .at_prd(at_prd), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic [2:0]       cfg_addr,
  input logic [CNT_W-1:0] cfg_data,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] prd_q,
  input logic [CNT_W-1:0] cmp_act_a,
  input logic [2:0]       cmp_mode_a
);
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_q >= prd_q) |=> cnt_q == '0);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_q < prd_q) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_addr == 3'd1 && !cmp_mode_a[2]) |=> cmp_act_a == $past(cfg_data));

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode_a[2] && cmp_mode_a[1] && !(cfg_valid && cfg_addr == 3'd1)) |=> $stable(cmp_act_a));

  p_idle_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt_q == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pwm_out));

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n) cfg_ready);
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
  .pwm_out(pwm_out), .cnt_q(cnt_q), .prd_q(prd_q),
  .cmp_act_a(cmp_act_a), .cmp_mode_a(cmp_mode_a)
);

// File: tb/pwm_shadow_gen_tb_top.sv
module pwm_shadow_gen_tb_top;
  localparam int CNT_W   = 16;
  localparam int PRD_RST = 100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_en = 1'b0;
  logic             cfg_valid = 1'b0;
  logic             cfg_ready;
  logic [2:0]       cfg_addr = '0;
  logic [CNT_W-1:0] cfg_data = '0;
  logic             pwm_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase = "R10";
  bit compare_on = 1'b0;

  always #2 clk = ~clk;

  pwm_shadow_gen #(.CNT_W(CNT_W), .PRD_RST(PRD_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .pwm_out(pwm_out)
  );

  // behavioural reference
  int m_prd, m_sa, m_sb, m_wa, m_wb, m_mode, m_act, m_cnt, m_out;

  function automatic int code_of(int tbl, int slot);
    return (tbl >> (2 * slot)) & 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prd = PRD_RST; m_sa = 0; m_sb = 0; m_wa = 0; m_wb = 0;
      m_mode = 0; m_act = 0; m_cnt = 0; m_out = 0;
    end else begin
      bit ez, ep, ea, eb, la, lb;
      int code;
      ez = run_en && m_cnt == 0;
      ep = run_en && m_cnt == m_prd;
      ea = run_en && m_cnt == m_wa && m_wa <= m_prd;
      eb = run_en && m_cnt == m_wb && m_wb <= m_prd;
      code = 0;
      if (ep && code_of(m_act, 1) != 0)      code = code_of(m_act, 1);
      else if (eb && code_of(m_act, 4) != 0) code = code_of(m_act, 4);
      else if (ea && code_of(m_act, 2) != 0) code = code_of(m_act, 2);
      else if (ez && code_of(m_act, 0) != 0) code = code_of(m_act, 0);
      if (code == 1) m_out = 0;
      else if (code == 2) m_out = 1;
      else if (code == 3) m_out = 1 - m_out;
      la = ((m_mode >> 2) & 1) && ((((m_mode & 3) == 0) && ez) || (((m_mode & 3) == 1) && ep));
      lb = ((m_mode >> 5) & 1) && (((((m_mode >> 3) & 3) == 0) && ez) || ((((m_mode >> 3) & 3) == 1) && ep));
      if (la) m_wa = m_sa;
      if (lb) m_wb = m_sb;
      if (!run_en) m_cnt = 0;
      else if (m_cnt >= m_prd) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (cfg_valid) begin
        case (cfg_addr)
          3'd0: m_prd = int'(cfg_data);
          3'd1: begin m_sa = int'(cfg_data); if (((m_mode >> 2) & 1) == 0) m_wa = m_sa; end
          3'd2: begin m_sb = int'(cfg_data); if (((m_mode >> 5) & 1) == 0) m_wb = m_sb; end
          3'd3: m_mode = int'(cfg_data) & 63;
          3'd4: m_act = int'(cfg_data) & 4095;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compare_on) begin
      check(phase, int'(pwm_out), m_out);
      check("R12", int'(cfg_ready), 1);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_addr  = 3'(addr);
    cfg_data  = CNT_W'(data);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    check("R10", int'(pwm_out), 0);   // reset drives output low
    check("R12", int'(cfg_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    compare_on = 1'b1;

    // R1 R6: high at period, low at compare A
    phase = "R6";
    wr(0, 9);
    wr(4, 24);
    wr(1, 4);
    run_en = 1'b1;
    phase = "R1";
    idle(30);

    phase = "R2";
    idle(3);
    wr(1, 6);
    idle(22);

    phase = "R4";
    wr(3, 5);
    idle(2);
    wr(1, 2);
    idle(25);

    phase = "R3";
    wr(3, 4);
    idle(3);
    wr(1, 7);
    idle(25);

    // R9: writes every cycle so one meets the load event
    phase = "R9";
    wr(3, 5);
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      cfg_valid = 1'b1; cfg_addr = 3'd1; cfg_data = CNT_W'(1 + (i % 8));
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    idle(25);

    phase = "R5";
    wr(3, 6);
    wr(1, 3);
    idle(25);
    wr(1, 8);
    idle(15);

    phase = "R8";
    wr(3, 0);
    wr(1, 15);
    idle(25);

    // R7: period low beats B invert and A high at count 9; A high beats zero low at 0
    phase = "R7";
    wr(4, 805);
    wr(2, 9);
    wr(1, 9);
    idle(25);
    wr(1, 0);
    idle(25);

    phase = "R11";
    wr(2, 12);
    wr(1, 4);
    wr(4, 3296);
    idle(25);

    // R13: invert on both compares
    phase = "R13";
    wr(2, 9);
    wr(4, 816);
    idle(25);
    wr(1, 7);
    idle(25);

    phase = "R10";
    idle(2);
    run_en = 1'b0;
    idle(10);
    run_en = 1'b1;
    idle(20);

    compare_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule